// File: doc/BRIEF.md
# Configurable GPIO Port with Pin Ownership Overrides

An eight-pin bidirectional general-purpose I/O port for a small register bus. Software sets a direction register and an output latch, and reads the pad levels through a two-flop synchronizer. Each pin can also be claimed by another function, and the port then changes what that pin drives and what the bus sees.

Three kinds of claim exist. The first is a per-pin analog-select bit, held in a port register, which blanks the digital read of the pin. The second is the clock circuit, which takes pins 6 and 7 whenever the oscillator mode uses an external crystal or an external clock. The third is per-pin LCD segment enables, which take pins 1, 4 and 5. While a pin is claimed by the clock circuit or the LCD, its pad output and output-enable come from the `alt_out_i`/`alt_oe_i` inputs.

The bus has no handshake. A write takes effect at the rising clock edge where `bus_we_i` is high. A read is combinational from `bus_addr_i`. Register addresses are 0 for the port (pad levels), 1 for the latch, 2 for direction and 3 for analog select.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, every direction bit is 1 (address 2 reads 0xFF). Every latch bit is 0 (address 1 reads 0x00). The analog-select register reads 0x2F, so pins 0–3 and 5 are analog and pin 4 is digital. With the LCD enables low, `pad_oe_o` is 0x00.
- R2: A write to address 0 or to address 1 loads the latch. A read of address 1 returns the latch.
- R3: For a pin that neither the clock circuit nor the LCD has claimed, `pad_oe_o` is the inverse of its direction bit (1 = input, driver off) and `pad_out_o` is its latch bit.
- R4: A read of address 0 returns the pad level. The level has passed through two flops, so a change on `pad_in_i` shows on the bus after the second rising edge and not after the first.
- R5: Address 3 holds the analog-select bits. Only bits 0–3 and 5 can be written, and the other bits always read 0. A pin whose bit is set reads 0 at address 0.
- R6: A pin in analog mode still drives its pad when its direction bit is 0.
- R7: With `osc_mode_i` at 0 (crystal) or 1 (external clock), pins 6 and 7 read 0 at addresses 0, 1 and 2. In the same modes, their `pad_oe_o`/`pad_out_o` follow `alt_oe_i`/`alt_out_i`.
- R8: With `osc_mode_i` at 2 or 3 (internal oscillator), pins 6 and 7 behave as ordinary digital I/O.
- R9: A set `lcd_seg_en_i` bit claims pin 1, 4 or 5. A claimed pin drives `alt_oe_i`/`alt_out_i` and reads 0 at address 0. Enable bits for any other pin have no effect.
- R10: Latch and direction writes to a claimed pin are stored. The stored values take control once the claim is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, 1 = drive |
| osc_mode_i | input | 2 | 0 crystal, 1 external clock, 2/3 internal oscillator |
| lcd_seg_en_i | input | 8 | Per-pin LCD segment enables |
| alt_out_i | input | 8 | Output value from the claiming function |
| alt_oe_i | input | 8 | Output enable from the claiming function |

## Verification
The bench reads the port one edge after a pad change and again after the second edge. A port with one synchronizer flop, or none, fails on the early read. It writes 0xFF to the analog-select register to expose bits that should not hold a value. It stores direction bits while the clock circuit holds pins 6 and 7, then releases that claim. A design that discarded those writes, or that kept hiding the bits, shows the wrong direction. It sets every LCD enable bit, so a port that honoured enables for pins other than 1, 4 and 5 changes `pad_oe_o` on pins it does not own.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_ANA  = 2'd3
  } gp_reg_e;

  typedef enum logic [1:0] {
    OSC_XTAL   = 2'd0,
    OSC_EXTCLK = 2'd1,
    OSC_INT_HI = 2'd2,
    OSC_INT_LO = 2'd3
  } osc_mode_e;

  function automatic logic osc_is_external(input logic [1:0] mode);
    return (mode == OSC_XTAL) || (mode == OSC_EXTCLK);
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_q_no
);
  logic stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= 1'b0;
      rst_q_no <= 1'b0;
    end else begin
      stage_q  <= 1'b1;
      rst_q_no <= stage_q;
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ovr_pkg::*;
#(
  parameter int          W        = 8,
  parameter logic [W-1:0] ANA_MASK = 8'h2F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] lat_q_o,
  output logic [W-1:0] dir_q_o,
  output logic [W-1:0] ana_q_o
);
  logic         lat_en, dir_en, ana_en;
  logic [W-1:0] lat_d, dir_d, ana_d;

  always_comb begin
    lat_en = we_i && ((addr_i == REG_PORT) || (addr_i == REG_LAT));
    dir_en = we_i && (addr_i == REG_DIR);
    ana_en = we_i && (addr_i == REG_ANA);
    lat_d  = wdata_i;
    dir_d  = wdata_i;
    ana_d  = wdata_i & ANA_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q_o <= '0;
      dir_q_o <= '1;
      ana_q_o <= ANA_MASK;
    end else begin
      if (lat_en) lat_q_o <= lat_d;
      if (dir_en) dir_q_o <= dir_d;
      if (ana_en) ana_q_o <= ana_d;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] ana_i,
  input  logic [W-1:0] osc_own_i,
  input  logic [W-1:0] lcd_own_i,
  input  logic [W-1:0] alt_out_i,
  input  logic [W-1:0] alt_oe_i,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] port_rd_o,
  output logic [W-1:0] lat_rd_o,
  output logic [W-1:0] dir_rd_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic claimed;
    always_comb begin
      claimed = osc_own_i[i] | lcd_own_i[i];
      if (claimed) begin
        pad_out_o[i] = alt_out_i[i];
        pad_oe_o[i]  = alt_oe_i[i];
      end else begin
        pad_out_o[i] = lat_i[i];
        pad_oe_o[i]  = ~dir_i[i];
      end
      port_rd_o[i] = sync_i[i] & ~claimed & ~ana_i[i];
      lat_rd_o[i]  = lat_i[i] & ~osc_own_i[i];
      dir_rd_o[i]  = dir_i[i] & ~osc_own_i[i];
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] ANA_MASK = 8'h2F,
  parameter logic [W-1:0] OSC_MASK = 8'hC0,
  parameter logic [W-1:0] LCD_MASK = 8'h32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   bus_addr_i,
  input  logic         bus_we_i,
  input  logic [W-1:0] bus_wdata_i,
  output logic [W-1:0] bus_rdata_o,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  input  logic [1:0]   osc_mode_i,
  input  logic [W-1:0] lcd_seg_en_i,
  input  logic [W-1:0] alt_out_i,
  input  logic [W-1:0] alt_oe_i
);
  logic         rst_q_n;
  logic [W-1:0] lat_q, dir_q, ana_q, sync_q;
  logic [W-1:0] osc_own, lcd_own;
  logic [W-1:0] port_rd, lat_rd, dir_rd;

  gpio_rst_sync u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_q_no (rst_q_n)
  );

  gpio_regs #(.W(W), .ANA_MASK(ANA_MASK)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_q_n),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .lat_q_o (lat_q),
    .dir_q_o (dir_q),
    .ana_q_o (ana_q)
  );

  gpio_sync2 #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_q_n),
    .d_i    (pad_in_i),
    .q_o    (sync_q)
  );

  always_comb begin
    osc_own = {W{osc_is_external(osc_mode_i)}} & OSC_MASK;
    lcd_own = lcd_seg_en_i & LCD_MASK;
  end

  gpio_pin_mux #(.W(W)) u_mux (
    .lat_i     (lat_q),
    .dir_i     (dir_q),
    .ana_i     (ana_q),
    .osc_own_i (osc_own),
    .lcd_own_i (lcd_own),
    .alt_out_i (alt_out_i),
    .alt_oe_i  (alt_oe_i),
    .sync_i    (sync_q),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o),
    .port_rd_o (port_rd),
    .lat_rd_o  (lat_rd),
    .dir_rd_o  (dir_rd)
  );

  always_comb begin
    unique case (bus_addr_i)
      REG_PORT: bus_rdata_o = port_rd;
      REG_LAT:  bus_rdata_o = lat_rd;
      REG_DIR:  bus_rdata_o = dir_rd;
      default:  bus_rdata_o = ana_q;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int           W        = 8,
  parameter logic [W-1:0] ANA_MASK = 8'h2F,
  parameter logic [W-1:0] OSC_MASK = 8'hC0
) (
  input logic         clk_i,
  input logic         rst_q_n,
  input logic [1:0]   bus_addr_i,
  input logic         bus_we_i,
  input logic [W-1:0] bus_wdata_i,
  input logic [W-1:0] bus_rdata_o,
  input logic [W-1:0] pad_oe_o,
  input logic [1:0]   osc_mode_i,
  input logic [W-1:0] alt_oe_i,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] ana_q,
  input logic [W-1:0] osc_own,
  input logic [W-1:0] lcd_own
);
  assert_lat_write_R2: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (bus_we_i && (bus_addr_i <= 2'd1)) |=> (lat_q == $past(bus_wdata_i)));

  assert_ana_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ((ana_q & ~ANA_MASK) == '0));

  assert_port_rd_ana_R5: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (bus_addr_i == 2'd0) |-> ((bus_rdata_o & ana_q) == '0));

  assert_osc_hide_R7: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ((osc_mode_i <= 2'd1) && (bus_addr_i != 2'd3)) |-> ((bus_rdata_o & OSC_MASK) == '0));

  assert_free_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ((~(osc_own | lcd_own) & (pad_oe_o ^ ~dir_q)) == '0));

  assert_osc_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ((osc_own & (pad_oe_o ^ alt_oe_i)) == '0));

  assert_lcd_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ((lcd_own & (pad_oe_o ^ alt_oe_i)) == '0));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .W(W), .ANA_MASK(ANA_MASK), .OSC_MASK(OSC_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_q_n     (rst_q_n),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pad_oe_o    (pad_oe_o),
  .osc_mode_i  (osc_mode_i),
  .alt_oe_i    (alt_oe_i),
  .lat_q       (lat_q),
  .dir_q       (dir_q),
  .ana_q       (ana_q),
  .osc_own     (osc_own),
  .lcd_own     (lcd_own)
);

// File: tb/gpio_ovr_port_bench.sv
module gpio_ovr_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       we;
  logic [7:0] wdata, rdata, pad_in, pad_out, pad_oe, lcd_en, alt_out, alt_oe;
  logic [1:0] osc_mode;
  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port u_gpio_ovr_port (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .osc_mode_i(osc_mode),
    .lcd_seg_en_i(lcd_en), .alt_out_i(alt_out), .alt_oe_i(alt_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_read(2'd2, v); check("R1 dir reset", v, 8'hFF);
    bus_read(2'd1, v); check("R1 latch reset", v, 8'h00);
    bus_read(2'd3, v); check("R1 analog reset", v, 8'h2F);
    check("R1 oe reset", pad_oe, 8'h00);
  endtask

  task automatic t_latch_dir;
    logic [7:0] v;
    bus_write(2'd1, 8'hA5);
    bus_read(2'd1, v); check("R2 latch via addr1", v, 8'hA5);
    bus_write(2'd0, 8'h3C);
    bus_read(2'd1, v); check("R2 latch via addr0", v, 8'h3C);
    bus_write(2'd2, 8'h0F);
    check("R3 oe from dir", pad_oe, 8'hF0);
    check("R3 out from latch", pad_out, 8'h3C);
    bus_write(2'd2, 8'h00);
    check("R6 analog pins drive", pad_oe & 8'h2F, 8'h2F);
    bus_write(2'd2, 8'hFF);
  endtask

  task automatic t_analog_sync;
    logic [7:0] v;
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, v); check("R5 analog mask", v, 8'h2F);
    bus_write(2'd3, 8'h00);
    @(negedge clk);
    pad_in = 8'h96;
    bus_read(2'd0, v); check("R4 before edges", v, 8'h00);
    @(negedge clk);
    bus_read(2'd0, v); check("R4 after one edge", v, 8'h00);
    @(negedge clk);
    bus_read(2'd0, v); check("R4 after two edges", v, 8'h96);
    bus_write(2'd3, 8'h2F);
    bus_read(2'd0, v); check("R5 analog reads zero", v, 8'h90);
    bus_write(2'd3, 8'h00);
  endtask

  task automatic t_osc;
    logic [7:0] v;
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hC0);
    pad_in = 8'hFF; alt_oe = 8'h40; alt_out = 8'h80;
    @(negedge clk); osc_mode = 2'd1;
    repeat (2) @(negedge clk);
    bus_read(2'd2, v); check("R7 dir hidden", v, 8'h00);
    bus_read(2'd1, v); check("R7 latch hidden", v, 8'h3F);
    bus_read(2'd0, v); check("R7 port hidden", v, 8'h3F);
    check("R7 oe from alt", pad_oe, 8'h7F);
    check("R7 out from alt", pad_out, 8'hBF);
    osc_mode = 2'd0;
    bus_write(2'd2, 8'h40);
    bus_read(2'd2, v); check("R7 crystal dir hidden", v, 8'h00);
    osc_mode = 2'd2;
    bus_read(2'd2, v); check("R10 dir kept, R8 visible", v, 8'h40);
    check("R8 oe from dir", pad_oe, 8'hBF);
    check("R8 out from latch", pad_out, 8'hFF);
    osc_mode = 2'd3;
    bus_read(2'd0, v); check("R8 port read low-int", v, 8'hFF);
  endtask

  task automatic t_lcd;
    logic [7:0] v;
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'h00);
    alt_out = 8'hFF; alt_oe = 8'h00; pad_in = 8'hFF;
    lcd_en = 8'hFF;
    #1;
    check("R9 oe only pins 1,4,5", pad_oe, 8'hCD);
    check("R9 out only pins 1,4,5", pad_out, 8'h32);
    bus_read(2'd0, v); check("R9 port reads zero", v, 8'hCD);
    bus_write(2'd1, 8'h32);
    bus_read(2'd1, v); check("R10 latch stored", v, 8'h32);
    lcd_en = 8'h00;
    #1;
    check("R10 latch drives after release", pad_out, 8'h32);
    check("R9 oe after release", pad_oe, 8'hFF);
  endtask

  initial begin
    rst_n = 1'b0; addr = 2'd0; we = 1'b0; wdata = 8'h00; pad_in = 8'h00;
    osc_mode = 2'd2; lcd_en = 8'h00; alt_out = 8'h00; alt_oe = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch_dir();
    t_analog_sync();
    t_osc();
    t_lcd();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule